// File: doc/BRIEF.md
# Receive Holding Queue with Break Insertion

This block is the small holding queue that sits between a serial receiver's deserializer and the host register interface of a UART. It stores up to four received bytes and returns them in arrival order. Bytes from the line are taken only while the receiver is enabled and the queue is not full. The deserializer sees this condition on a can-accept output.

A line break is handled differently. A break event always enters a zero byte and raises a sticky break-change flag. When the queue is already full, the zero replaces the newest entry, so a break is never lost.

The host reads the oldest byte from the head output. It pulses a pop input to consume that byte. A receiver-clear input empties the queue in one cycle. Receiver-ready and queue-full are kept as registered status bits.

Top module: `rxq_hold`

## Requirements
- R1: After reset the queue is empty: `rx_ready`, `rx_full` and `brk_flag` are 0 and `head_data` is 0.
- R2: The queue holds up to DEPTH (4) bytes and returns them oldest first.
- R3: Any accepted byte sets `rx_ready`. `rx_full` is set in the cycle after the occupancy reaches 4. Both bits always match the occupancy: ready means at least one entry, full means four entries.
- R4: `can_accept` is 1 exactly when `rx_en` is 1 and `rx_full` is 0. A `line_vld` byte offered while `can_accept` is 0 is dropped and changes no output.
- R5: A `brk_evt` pulse enters a zero byte whatever the value of `rx_en`. It also sets `brk_flag`. If a line byte is offered in the same cycle, the break wins and the line byte is dropped.
- R6: A break that arrives while the queue holds 4 bytes replaces the newest entry with zero. The occupancy stays at 4 and the three older bytes are kept.
- R7: A `pop_req` on a non-empty queue consumes the byte shown on `head_data` and clears `rx_full`. `rx_ready` clears when the last byte is consumed.
- R8: While the queue is empty, `head_data` reads 0. A pop on an empty queue changes nothing.
- R9: `rx_clr` empties the queue and clears `rx_ready` and `rx_full` in the next cycle. It takes priority over any pop, line byte or break data offered in the same cycle.
- R10: When a pop and a push fall in the same cycle, the pop is applied first. The occupancy then stays the same, no overwrite happens, and the pushed byte is queued behind the remaining ones.
- R11: `brk_ack` clears `brk_flag`. If `brk_ack` and `brk_evt` arrive together, the flag is set. `rx_clr` does not touch `brk_flag`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_en | input | 1 | Receiver enabled; gates line bytes |
| rx_clr | input | 1 | Receiver clear: empties the queue |
| line_vld | input | 1 | Deserializer offers a byte this cycle |
| line_data | input | 8 | Offered byte |
| brk_evt | input | 1 | Break detected on the line |
| brk_ack | input | 1 | Clears the break-change flag |
| pop_req | input | 1 | Host consumes the head byte |
| head_data | output | 8 | Oldest byte, or 0 when empty |
| rx_ready | output | 1 | At least one byte held |
| rx_full | output | 1 | Four bytes held |
| can_accept | output | 1 | A line byte would be taken this cycle |
| brk_flag | output | 1 | Sticky break-change flag |

## Verification
The outputs follow three timings. `can_accept` depends combinationally on `rx_en` in the same cycle. `head_data`, `rx_ready`, `rx_full` and `brk_flag` reflect a push, pop, clear or break one clock edge after the cycle in which that stimulus was presented. The bench drives every input on the falling edge and waits one time unit. It then compares all five outputs against its own queue model, which was last advanced at the preceding rising edge. Consuming a byte is judged by the `head_data` value seen in the cycle the pop is presented, before the edge that removes it.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Circular index advance with wrap at depth.
  function automatic int unsigned wrap_next(input int unsigned p, input int unsigned depth);
    return (p + 1 == depth) ? 0 : p + 1;
  endfunction

  // Circular index step back with wrap at depth.
  function automatic int unsigned wrap_prev(input int unsigned p, input int unsigned depth);
    return (p == 0) ? depth - 1 : p - 1;
  endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [PW-1:0]    wr_idx,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [PW-1:0]    rd_idx,
  output logic [WIDTH-1:0] rd_data
);

  logic [WIDTH-1:0] slot_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        slot_q[g] <= '0;
      else if (wr_en && (wr_idx == PW'(g)))
        slot_q[g] <= wr_data;
    end
  end

  assign rd_data = slot_q[rd_idx];

endmodule

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          rx_clr,
  input  logic          line_vld,
  input  logic          brk_evt,
  input  logic          pop_req,
  output logic          wr_en,
  output logic [PW-1:0] wr_idx,
  output logic [PW-1:0] rd_idx,
  output logic          not_empty,
  output logic          ready_q,
  output logic          full_q,
  output logic          can_accept
);

  logic [PW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q, cnt_mid, cnt_d;
  logic [PW-1:0] wr_d, rd_d;
  logic          ready_d, full_d;

  // Named internal events
  logic pop_fire, line_fire, brk_fire, push_fire, ovw_fire;

  assign can_accept = rx_en && !full_q;
  assign not_empty  = (cnt_q != '0);
  assign pop_fire   = pop_req && not_empty && !rx_clr;
  assign line_fire  = line_vld && can_accept && !rx_clr;
  assign brk_fire   = brk_evt && !rx_clr;
  assign push_fire  = brk_fire || line_fire;
  assign cnt_mid    = cnt_q - CW'(pop_fire);
  assign ovw_fire   = push_fire && (cnt_mid == CW'(DEPTH));

  assign wr_en  = push_fire;
  assign wr_idx = ovw_fire ? PW'(wrap_prev(32'(wr_q), DEPTH)) : wr_q;
  assign rd_idx = rd_q;

  always_comb begin
    rd_d    = rd_q;
    wr_d    = wr_q;
    cnt_d   = cnt_mid;
    ready_d = ready_q;
    full_d  = full_q;
    if (rx_clr) begin
      rd_d    = '0;
      wr_d    = '0;
      cnt_d   = '0;
      ready_d = 1'b0;
      full_d  = 1'b0;
    end else begin
      if (pop_fire) begin
        rd_d   = PW'(wrap_next(32'(rd_q), DEPTH));
        full_d = 1'b0;
        if (cnt_mid == '0) ready_d = 1'b0;
      end
      if (push_fire) begin
        ready_d = 1'b1;
        if (!ovw_fire) begin
          wr_d  = PW'(wrap_next(32'(wr_q), DEPTH));
          cnt_d = cnt_mid + CW'(1);
        end
        if (ovw_fire || (cnt_mid + CW'(1) == CW'(DEPTH))) full_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q    <= '0;
      wr_q    <= '0;
      cnt_q   <= '0;
      ready_q <= 1'b0;
      full_q  <= 1'b0;
    end else begin
      rd_q    <= rd_d;
      wr_q    <= wr_d;
      cnt_q   <= cnt_d;
      ready_q <= ready_d;
      full_q  <= full_d;
    end
  end

  AST_READY_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    ready_q == (cnt_q != '0)); // R3
  AST_FULL_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    full_q == (cnt_q == CW'(DEPTH))); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH)); // R6
  AST_CLEAR_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (cnt_q == '0) && !ready_q && !full_q); // R9
  AST_EMPTY_POP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req && !not_empty && !brk_evt && !line_vld && !rx_clr) |=> $stable(cnt_q)); // R8
  AST_BLOCKED_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (line_vld && !can_accept && !brk_evt && !pop_req && !rx_clr) |=> $stable(cnt_q) && $stable(wr_q)); // R4
  AST_BREAK_AT_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && full_q && !pop_req && !rx_clr) |=> full_q); // R6
  AST_SWAP_KEEPS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_fire && push_fire) |=> $stable(cnt_q)); // R10

endmodule

// File: rtl/rxq_hold.sv
module rxq_hold #(
  parameter int WIDTH = 8,
  parameter int DEPTH = 4,
  localparam int PW = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_en,
  input  logic             rx_clr,
  input  logic             line_vld,
  input  logic [WIDTH-1:0] line_data,
  input  logic             brk_evt,
  input  logic             brk_ack,
  input  logic             pop_req,
  output logic [WIDTH-1:0] head_data,
  output logic             rx_ready,
  output logic             rx_full,
  output logic             can_accept,
  output logic             brk_flag
);

  logic             wr_en, not_empty;
  logic [PW-1:0]    wr_idx, rd_idx;
  logic [WIDTH-1:0] wr_data, rd_data;

  // Break always inserts a zero byte in place of line data.
  assign wr_data = brk_evt ? '0 : line_data;

  rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_en     (rx_en),
    .rx_clr    (rx_clr),
    .line_vld  (line_vld),
    .brk_evt   (brk_evt),
    .pop_req   (pop_req),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .rd_idx    (rd_idx),
    .not_empty (not_empty),
    .ready_q   (rx_ready),
    .full_q    (rx_full),
    .can_accept(can_accept)
  );

  rxq_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .wr_idx (wr_idx),
    .wr_data(wr_data),
    .rd_idx (rd_idx),
    .rd_data(rd_data)
  );

  assign head_data = not_empty ? rd_data : '0;

  // Sticky break-change flag: set wins over acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       brk_flag <= 1'b0;
    else if (brk_evt) brk_flag <= 1'b1;
    else if (brk_ack) brk_flag <= 1'b0;
  end

  AST_BRK_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    brk_evt |=> brk_flag); // R5
  AST_ACK_LOWERS: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_ack && !brk_evt) |=> !brk_flag); // R11
  AST_EMPTY_HEAD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_ready |-> (head_data == '0)); // R8
  AST_BRK_NOT_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_evt && !rx_clr) |=> rx_ready); // R5

endmodule

// File: tb/sim_rxq_hold.sv
`timescale 1ns/1ps
module sim_rxq_hold;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx_en = 1'b0, rx_clr = 1'b0, line_vld = 1'b0;
  logic [7:0] line_data = '0;
  logic       brk_evt = 1'b0, brk_ack = 1'b0, pop_req = 1'b0;
  logic [7:0] head_data;
  logic       rx_ready, rx_full, can_accept, brk_flag;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // Bench model
  logic [7:0] mq [4];
  int         mcnt = 0;
  bit         mbrk = 0;

  always #4 clk = ~clk;

  rxq_hold u0 (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .rx_clr(rx_clr),
    .line_vld(line_vld), .line_data(line_data), .brk_evt(brk_evt),
    .brk_ack(brk_ack), .pop_req(pop_req), .head_data(head_data),
    .rx_ready(rx_ready), .rx_full(rx_full), .can_accept(can_accept),
    .brk_flag(brk_flag)
  );

  function automatic logic [7:0] exp_head();
    return (mcnt != 0) ? mq[0] : 8'h00;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic model_edge(input bit pop, input bit lv, input logic [7:0] ld,
                            input bit en, input bit brk, input bit clr, input bit ack);
    bit was_full;
    bit take;
    logic [7:0] d;
    if (brk) mbrk = 1;
    else if (ack) mbrk = 0;
    if (clr) begin
      mcnt = 0;
    end else begin
      was_full = (mcnt == 4);
      if (pop && mcnt > 0) begin
        for (int i = 0; i < 3; i++) mq[i] = mq[i+1];
        mcnt--;
      end
      take = brk || (lv && en && !was_full);
      d = brk ? 8'h00 : ld;
      if (take) begin
        if (mcnt == 4) mq[3] = d;
        else begin mq[mcnt] = d; mcnt++; end
      end
    end
  endtask

  // One cycle: drive at falling edge, check, then advance model at rising edge.
  task automatic step(input string tag, input bit pop, input bit lv, input logic [7:0] ld,
                      input bit en, input bit brk, input bit clr, input bit ack);
    @(negedge clk);
    pop_req = pop; line_vld = lv; line_data = ld; rx_en = en;
    brk_evt = brk; rx_clr = clr; brk_ack = ack;
    #1;
    chk(tag, "head_data", int'(head_data), int'(exp_head()));
    chk(tag, "rx_ready", int'(rx_ready), int'(mcnt != 0));
    chk(tag, "rx_full", int'(rx_full), int'(mcnt == 4));
    chk(tag, "can_accept", int'(can_accept), int'(en && (mcnt != 4)));
    chk(tag, "brk_flag", int'(brk_flag), int'(mbrk));
    @(posedge clk);
    model_edge(pop, lv, ld, en, brk, clr, ack);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20250611));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    step("R1", 0, 0, 8'h00, 0, 0, 0, 0);
    // R4: receiver disabled, byte dropped
    step("R4", 0, 1, 8'hA5, 0, 0, 0, 0);
    step("R4", 0, 0, 8'h00, 1, 0, 0, 0);
    // R2 R3: fill to four
    step("R3", 0, 1, 8'h11, 1, 0, 0, 0);
    step("R2", 0, 1, 8'h22, 1, 0, 0, 0);
    step("R2", 0, 1, 8'h33, 1, 0, 0, 0);
    step("R3", 0, 1, 8'h44, 1, 0, 0, 0);
    // R4: full, byte dropped
    step("R4", 0, 1, 8'h55, 1, 0, 0, 0);
    // R6: break at full overwrites newest
    step("R6", 0, 0, 8'h00, 1, 1, 0, 0);
    // R11: ack together with break keeps flag, then ack alone clears
    step("R11", 0, 0, 8'h00, 1, 1, 0, 1);
    step("R11", 0, 0, 8'h00, 1, 0, 0, 1);
    // R7: drain in order
    for (int i = 0; i < 4; i++) step("R7", 1, 0, 8'h00, 1, 0, 0, 0);
    // R8: pop while empty
    step("R8", 1, 0, 8'h00, 1, 0, 0, 0);
    step("R8", 0, 0, 8'h00, 1, 0, 0, 0);
    // R5: break with receiver disabled and competing line byte
    step("R5", 0, 1, 8'h77, 0, 1, 0, 0);
    step("R5", 0, 0, 8'h00, 0, 0, 0, 1);
    // R10: fill, then pop and push together at three and at four
    step("R10", 0, 1, 8'h81, 1, 0, 0, 0);
    step("R10", 0, 1, 8'h82, 1, 0, 0, 0);
    step("R10", 1, 1, 8'h83, 1, 0, 0, 0);
    step("R10", 0, 1, 8'h84, 1, 0, 0, 0);
    step("R10", 1, 0, 8'h00, 1, 1, 0, 0);
    step("R10", 0, 0, 8'h00, 1, 0, 0, 0);
    // R9: clear beats pop, push and break data
    step("R9", 1, 1, 8'h99, 1, 1, 1, 0);
    step("R9", 0, 0, 8'h00, 1, 0, 0, 1);

    // Constrained random mix, checked by the model
    for (int n = 0; n < 4000; n++) begin
      step("R10", ($urandom % 100) < 35, ($urandom % 100) < 55, 8'($urandom),
           ($urandom % 100) < 85, ($urandom % 100) < 5,
           ($urandom % 100) < 2, ($urandom % 100) < 10);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule